// File: doc/BRIEF.md
# Dual-Strobe Reversible Counter

This block is a small reversible binary counter with two separate count strobes, one for counting up and one for counting down. Direction comes from which strobe rises, not from a direction bit. The block runs on a single system clock. All four control pins pass through a two-stage synchronizer. A count takes place when the block sees a rising edge on a synchronized strobe.

A parallel load copies a data word into the count for as long as it is held active. A clear input forces the count to zero and wins over everything else. Two active-low flags mark the terminal states: a carry at the top value and a borrow at zero. Each flag repeats the low phase of its own strobe. This lets the flags of one instance drive the up and down strobes of the next, so the instances chain into a wider counter with no extra logic.

A three-state controller chooses what the count register does. The states are CLEAR, LOAD and RUN. The transition to CLEAR happens from any state when clear is high. The transition to LOAD happens from any state when load is active and clear is low. The transition to RUN happens when neither is active. In RUN, a legal edge on one strobe steps the count. An edge on one strobe while the other strobe is low is illegal: the count holds and an error flag is raised instead.

Top module: `updn_strobe_counter`

## Requirements
- R1: A rising edge on `up_stb` while `dn_stb` is high adds one to `q`, and the count wraps from the all-ones value to 0.
- R2: A rising edge on `dn_stb` while `up_stb` is high subtracts one from `q`, and the count wraps from 0 to the all-ones value. Returning a low `dn_stb` to high while `up_stb` is high is such an edge.
- R3: While `clear` is high, `q` is 0. This holds whatever `load_n`, `din` and both strobes do.
- R4: While `load_n` is low and `clear` is low, `q` follows `din` continuously, and strobe edges have no effect on `q`.
- R5: `carry_n` is low only when `q` is all ones and `up_stb` is low; otherwise it is high.
- R6: `borrow_n` is low only when `q` is 0 and `dn_stb` is low; otherwise it is high.
- R7: A strobe that is held low through a clear or a load, and is still low after it ends, gives a valid count on its next rising edge.
- R8: In two cases the edge is illegal: a strobe rises while the other strobe is low, or both strobes rise in the same clock cycle. In either case `q` is unchanged and `step_err` is high for exactly one clock cycle.
- R9: Suppose a strobe pin changes just after one falling clock edge. After the second following rising edge `q` still holds its old value. After the third it holds the new value.
- R10: Two instances, with the second driven by the first one's `carry_n` and `borrow_n`, act as an 8-bit binary counter. This includes the wrap from 255 to 0 and from 0 to 255.
- R11: After system reset, `q` is 0, both flags are high and `step_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| up_stb | input | 1 | Count-up strobe; rising edge counts, idles high |
| dn_stb | input | 1 | Count-down strobe; rising edge counts, idles high |
| load_n | input | 1 | Parallel load, active low, level sensitive |
| clear | input | 1 | Master clear, active high, highest priority |
| din | input | CNT_W | Parallel load data |
| q | output | CNT_W | Current count |
| carry_n | output | 1 | Terminal count up flag, active low |
| borrow_n | output | 1 | Terminal count down flag, active low |
| step_err | output | 1 | One-cycle pulse on an illegal strobe edge |

## Verification
The bench chains two instances and drives the count up through 255 and down through 0. A design that handled the flags or the wrap wrongly would skip or repeat the upper nibble at each lower-nibble rollover. It holds a strobe low across a clear and across a load. An edge detector that was re-armed by those modes would lose the first count afterwards. It raises a strobe while the other strobe is low, and raises both strobes together. A design without the illegal-edge rule would step the count instead of holding it and pulsing the error flag. It also checks the exact latency from strobe pin to count, and that load follows data changes while ignoring strobe edges.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_RUN   = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        ACT_HOLD = 3'd0,
        ACT_ZERO = 3'd1,
        ACT_LOAD = 3'd2,
        ACT_INC  = 3'd3,
        ACT_DEC  = 3'd4,
        ACT_BAD  = 3'd5
    } act_e;
endpackage

// File: rtl/cnt_sync.sv
module cnt_sync #(
    parameter int          W      = 1,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] INIT  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{INIT}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
    import cnt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  up_s,
    input  logic  dn_s,
    input  logic  ld_n_s,
    input  logic  clr_s,
    output act_e  act,
    output logic  err
);
    mode_e state_q, state_d;
    logic  up_p, dn_p;
    logic  up_rise, dn_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_CLEAR;
            up_p    <= 1'b1;
            dn_p    <= 1'b1;
            err     <= 1'b0;
        end else begin
            state_q <= state_d;
            up_p    <= up_s;
            dn_p    <= dn_s;
            err     <= (act == ACT_BAD);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_CLEAR: if (!clr_s) state_d = ld_n_s ? MODE_RUN : MODE_LOAD;
            MODE_LOAD: begin
                if (clr_s)       state_d = MODE_CLEAR;
                else if (ld_n_s) state_d = MODE_RUN;
            end
            MODE_RUN: begin
                if (clr_s)        state_d = MODE_CLEAR;
                else if (!ld_n_s) state_d = MODE_LOAD;
            end
            default: state_d = MODE_CLEAR;
        endcase
    end

    assign up_rise = up_s & ~up_p;
    assign dn_rise = dn_s & ~dn_p;

    always_comb begin
        act = ACT_HOLD;
        unique case (state_q)
            MODE_CLEAR: act = ACT_ZERO;
            MODE_LOAD:  act = ACT_LOAD;
            MODE_RUN: begin
                if (up_rise && dn_rise) act = ACT_BAD;
                else if (up_rise)       act = dn_s ? ACT_INC : ACT_BAD;
                else if (dn_rise)       act = up_s ? ACT_DEC : ACT_BAD;
            end
            default: act = ACT_HOLD;
        endcase
    end

    // R8
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R3
    clear_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_s && state_q == MODE_CLEAR) |-> act == ACT_ZERO);
endmodule

// File: rtl/cnt_core.sv
module cnt_core
    import cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  act_e         act,
    input  logic [W-1:0] din,
    input  logic         up_s,
    input  logic         dn_s,
    output logic [W-1:0] q,
    output logic         carry_n,
    output logic         borrow_n
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] TOPV = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (act)
                ACT_ZERO: q <= '0;
                ACT_LOAD: q <= din;
                ACT_INC:  q <= q + ONE;
                ACT_DEC:  q <= q - ONE;
                default:  q <= q;
            endcase
        end
    end

    assign carry_n  = ~((q == TOPV) & ~up_s);
    assign borrow_n = ~((q == '0)   & ~dn_s);

    // R1
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_INC |=> q == $past(q) + ONE);

    // R2
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_DEC |=> q == $past(q) - ONE);

    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_ZERO |=> q == '0);

    // R4
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_LOAD |=> q == $past(din));

    // R8
    bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_BAD |=> $stable(q));
endmodule

// File: rtl/updn_strobe_counter.sv
module updn_strobe_counter
    import cnt_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_stb,
    input  logic             dn_stb,
    input  logic             load_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] din,
    output logic [CNT_W-1:0] q,
    output logic             carry_n,
    output logic             borrow_n,
    output logic             step_err
);
    localparam int          CTL_W    = 4;
    localparam logic [3:0]  CTL_IDLE = 4'b1110;

    logic [CTL_W-1:0] ctl_raw, ctl_s;
    logic             up_s, dn_s, ld_n_s, clr_s;
    act_e             act;

    assign ctl_raw = {up_stb, dn_stb, load_n, clear};

    cnt_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .INIT(CTL_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctl_raw),
        .q     (ctl_s)
    );

    assign {up_s, dn_s, ld_n_s, clr_s} = ctl_s;

    cnt_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .up_s   (up_s),
        .dn_s   (dn_s),
        .ld_n_s (ld_n_s),
        .clr_s  (clr_s),
        .act    (act),
        .err    (step_err)
    );

    cnt_core #(.W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .din      (din),
        .up_s     (up_s),
        .dn_s     (dn_s),
        .q        (q),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );

    // R5
    carry_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n |-> (!up_s && q == '1));

    // R6
    borrow_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n |-> (!dn_s && q == '0));
endmodule

// File: tb/sim_updn_strobe_counter.sv
module sim_updn_strobe_counter;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, up, dn, ld_n, clr;
    logic [7:0] din;
    logic [3:0] q0, q1;
    logic       c0, b0, e0, c1, b1, e1;

    int checks   = 0;
    int failures = 0;
    int err_seen = 0;
    int model    = 0;

    updn_strobe_counter u0 (
        .clk(clk), .rst_n(rst_n), .up_stb(up), .dn_stb(dn), .load_n(ld_n),
        .clear(clr), .din(din[3:0]), .q(q0), .carry_n(c0), .borrow_n(b0),
        .step_err(e0)
    );

    updn_strobe_counter u1 (
        .clk(clk), .rst_n(rst_n), .up_stb(c0), .dn_stb(b0), .load_n(ld_n),
        .clear(clr), .din(din[7:4]), .q(q1), .carry_n(c1), .borrow_n(b1),
        .step_err(e1)
    );

    always @(negedge clk) if (rst_n && e0) err_seen++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_total(input string tag);
        chk(tag, int'({q1, q0}), model);
    endtask

    task automatic do_load(input int v);
        din = 8'(v); ld_n = 1'b0; tick(8);
        ld_n = 1'b1; tick(8);
        model = v;
    endtask

    task automatic do_clear();
        clr = 1'b1; tick(8);
        clr = 1'b0; tick(8);
        model = 0;
    endtask

    task automatic step_up();
        up = 1'b0; tick(6);
        up = 1'b1; tick(12);
        model = (model + 1) % 256;
    endtask

    task automatic step_dn();
        dn = 1'b0; tick(6);
        dn = 1'b1; tick(12);
        model = (model + 255) % 256;
    endtask

    task automatic t_reset();
        chk("R11 q", int'(q0), 0);
        chk("R11 carry_n", int'(c0), 1);
        chk("R11 borrow_n", int'(b0), 1);
        chk("R11 step_err", int'(e0), 0);
    endtask

    task automatic t_latency();
        up = 1'b0; tick(6);
        up = 1'b1; tick(2);
        chk("R9 before third edge", int'(q0), 0);
        tick(1);
        chk("R9 at third edge", int'(q0), 1);
        tick(10);
        model = 1;
        chk_total("R9 settled");
    endtask

    task automatic t_count_up();
        do_clear();
        for (int i = 0; i < 260; i++) begin
            step_up();
            chk("R1 lower nibble", int'(q0), model % 16);
            chk_total("R10 cascade up");
        end
    endtask

    task automatic t_count_dn();
        for (int i = 0; i < 260; i++) begin
            step_dn();
            chk("R2 lower nibble", int'(q0), model % 16);
            chk_total("R10 cascade down");
        end
    endtask

    task automatic t_flags();
        do_load(8'h2F);
        chk("R5 carry idle high", int'(c0), 1);
        up = 1'b0; tick(4);
        chk("R5 carry low", int'(c0), 0);
        chk("R6 borrow high at 15", int'(b0), 1);
        up = 1'b1; tick(4);
        chk("R5 carry released", int'(c0), 1);
        tick(10);
        model = 8'h30;
        chk_total("R1 wrap into upper");
        do_load(8'h50);
        dn = 1'b0; tick(4);
        chk("R6 borrow low", int'(b0), 0);
        chk("R5 carry high at 0", int'(c0), 1);
        dn = 1'b1; tick(14);
        model = 8'h4F;
        chk_total("R2 wrap into upper");
    endtask

    task automatic t_load();
        ld_n = 1'b0; din = 8'h13; tick(8);
        chk("R4 load first", int'({q1, q0}), 8'h13);
        din = 8'h9A; tick(6);
        chk("R4 load follows", int'({q1, q0}), 8'h9A);
        up = 1'b0; tick(5);
        up = 1'b1; tick(8);
        chk("R4 strobe ignored", int'({q1, q0}), 8'h9A);
        ld_n = 1'b1; tick(8);
        model = 8'h9A;
        chk_total("R4 after release");
    endtask

    task automatic t_clear();
        do_load(8'h3C);
        clr = 1'b1; ld_n = 1'b0; din = 8'h77; up = 1'b0; tick(8);
        chk("R3 clear over load", int'({q1, q0}), 0);
        up = 1'b1; tick(8);
        chk("R3 clear over strobe", int'({q1, q0}), 0);
        clr = 1'b0; ld_n = 1'b1; tick(8);
        model = 0;
        chk_total("R3 after release");
    endtask

    task automatic t_held();
        do_load(8'h25);
        up = 1'b0; tick(4);
        clr = 1'b1; tick(8);
        clr = 1'b0; tick(8);
        chk("R7 cleared", int'({q1, q0}), 0);
        up = 1'b1; tick(12);
        model = 1;
        chk_total("R7 count after clear");
        dn = 1'b0; tick(4);
        din = 8'h44; ld_n = 1'b0; tick(8);
        ld_n = 1'b1; tick(8);
        chk("R7 loaded", int'({q1, q0}), 8'h44);
        dn = 1'b1; tick(12);
        model = 8'h43;
        chk_total("R7 count after load");
    endtask

    task automatic t_illegal();
        int base;
        do_load(8'h66);
        base = err_seen;
        dn = 1'b0; tick(6);
        up = 1'b0; tick(6);
        up = 1'b1; tick(12);
        chk("R8 held on up edge", int'({q1, q0}), 8'h66);
        chk("R8 one error pulse", err_seen - base, 1);
        dn = 1'b1; tick(12);
        model = 8'h65;
        chk_total("R2 direction change");
        up = 1'b0; dn = 1'b0; tick(6);
        up = 1'b1; dn = 1'b1; tick(12);
        chk("R8 held on dual edge", int'({q1, q0}), 8'h65);
        chk("R8 second pulse", err_seen - base, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; up = 1'b1; dn = 1'b1; ld_n = 1'b1; clr = 1'b0; din = '0;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_latency();
        t_count_up();
        t_count_dn();
        t_flags();
        t_load();
        t_clear();
        t_held();
        t_illegal();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule